// File: doc/BRIEF.md
# Automatic Half-Duplex Direction Controller

This block sits next to a UART transmitter and drives the enable of a half-duplex line driver. The enable is an RTS-style output, named `dir_out`, where 1 means the driver is on. In automatic mode the block turns the driver on when software queues a byte. It then holds back the launch of that byte's start bit until the line has had one or more bit times to settle. It turns the driver off only after the final stop bit of the last queued character has left the shift register. In the same mode it also moves the transmit-empty interrupt source. The interrupt no longer fires when the holding register or FIFO is empty. It fires only when the shift register has finished as well.

With automatic mode off, the block passes the software RTS value through to the output. The interrupt source is then plain holding-register empty, as on a classic UART. Baud generation and the serial shifter are outside the block. The shifter reports a strobe at the end of each stop bit and a bit-time tick. It reads `launch_ok` before it starts a character.

Top module: `auto_dir_ctrl`

## Requirements
- R1: Synchronous active-low reset. In any clock edge with `rst_n` low, `dir_out` becomes 1 if `auto_en` is 0 and 0 if `auto_en` is 1, and `tx_irq` becomes 0. After that edge, `launch_ok` reads 1 with `auto_en` 0 and 0 with `auto_en` 1.
- R2: With `auto_en` 0, `dir_out` takes the value `sw_rts` had at the previous clock edge.
- R3: With `auto_en` 0, `tx_irq` takes the value `tx_fifo_empty` had at the previous edge, whatever `tsr_busy` is.
- R4: With `auto_en` 1, a `byte_written` pulse makes `dir_out` 1 at the next clock edge.
- R5: With `auto_en` 1, `dir_out` goes to 0 at the edge after a cycle in which `stop_bit_done` and `tx_fifo_empty` are both 1 and `byte_written` is 0. A `stop_bit_done` with `tx_fifo_empty` 0 leaves `dir_out` at 1.
- R6: With `auto_en` 1, when `byte_written` and a final `stop_bit_done` arrive in the same cycle, the write wins and `dir_out` is 1 after the edge.
- R7: With `auto_en` 1, `tx_irq` takes the value of (`tx_fifo_empty` and not `tsr_busy`) from the previous edge.
- R8: With `auto_en` 1, each 0-to-1 change of `dir_out` arms a guard of `GUARD_BITS` bit times, with a default of 1. `launch_ok` stays 0 until that many `bit_tick` pulses have been seen in cycles after the rising edge. It reads 1 after the edge that samples the last of them. A tick in the same cycle as the arming write does not count. A write while `dir_out` is already 1 does not re-arm the guard.
- R9: With `auto_en` 1, `launch_ok` is 0 whenever `dir_out` is 0. With `auto_en` 0, `launch_ok` is always 1.
- R10: With `auto_en` 1, `sw_rts` has no effect on `dir_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_en | input | 1 | 1 selects automatic direction control |
| sw_rts | input | 1 | Software RTS value, used when automatic mode is off |
| byte_written | input | 1 | One-cycle pulse: byte written to holding register or FIFO |
| tx_fifo_empty | input | 1 | Holding register and transmit FIFO are empty |
| tsr_busy | input | 1 | Shift register is still sending |
| stop_bit_done | input | 1 | One-cycle strobe at the end of a stop bit |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| dir_out | output | 1 | Line-driver enable, 1 = transmit |
| tx_irq | output | 1 | Transmit-empty interrupt source |
| launch_ok | output | 1 | Shifter may start a character's start bit |

## Verification
In automatic mode, a write into the transmit queue and the end-of-stop-bit strobe of the last character can fall in the same cycle. These are the turn-on and turn-off conditions of the direction output. The bench drives both pulses together twice: once while the driver is on and once while it is off. It expects the output to be 1 after the edge in both cases. In the second case it also expects the settling guard to be armed again, so `launch_ok` must read 0.

// File: rtl/auto_dir_pkg.sv
// Package: shared direction encoding for the automatic direction controller.
// Assumes: nothing; holds only types and constants.
package auto_dir_pkg;

    // Line-driver direction as carried on dir_out.
    typedef enum logic {
        DIR_RECEIVE  = 1'b0,
        DIR_TRANSMIT = 1'b1
    } dir_e;

    // Direction taken at reset: receive when automatic control owns the line.
    function automatic dir_e reset_dir(input logic auto_mode);
        return auto_mode ? DIR_RECEIVE : DIR_TRANSMIT;
    endfunction

endpackage

// File: rtl/auto_dir_line.sv
// Module: direction register.
// Automatic mode: a queued byte turns the driver on; the stop-bit strobe of the
// last character (queue empty, no concurrent write) turns it off; the write wins.
// Manual mode: the register copies the software RTS value.
// Also flags the cycle in which a write turns the driver on (guard arming).
// Assumes: byte_written and stop_bit_done are single-cycle pulses.
module auto_dir_line
    import auto_dir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic sw_rts,
    input  logic byte_written,
    input  logic tx_fifo_empty,
    input  logic stop_bit_done,
    output logic dir_q,
    output logic arm_guard
);

    dir_e dir_r;
    dir_e dir_nxt;
    logic last_stop;

    // Last stop bit of the last character with nothing new queued.
    assign last_stop = stop_bit_done && tx_fifo_empty && !byte_written;

    // Next direction per mode.
    always_comb begin
        dir_nxt = dir_r;
        if (!auto_en) begin
            dir_nxt = sw_rts ? DIR_TRANSMIT : DIR_RECEIVE;
        end else if (byte_written) begin
            dir_nxt = DIR_TRANSMIT;
        end else if (last_stop) begin
            dir_nxt = DIR_RECEIVE;
        end
    end

    // Direction register with mode-dependent reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_r <= reset_dir(auto_en);
        end else begin
            dir_r <= dir_nxt;
        end
    end

    // A write that finds the driver off arms the settling guard.
    assign arm_guard = auto_en && byte_written && (dir_r == DIR_RECEIVE);
    assign dir_q     = (dir_r == DIR_TRANSMIT);

endmodule

// File: rtl/auto_dir_guard.sv
// Module: settling guard. Counts GUARD_BITS bit ticks after the driver turns
// on and reports when the start bit may launch.
// Assumes: bit_tick is a single-cycle strobe; arm only while driver is off.
module auto_dir_guard #(
    parameter int GUARD_BITS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic arm,
    input  logic bit_tick,
    output logic settled
);

    generate
        if (GUARD_BITS == 0) begin : g_no_guard
            // No settling time requested.
            assign settled = 1'b1;
        end else begin : g_guard
            localparam int CNT_W = $clog2(GUARD_BITS + 1);
            localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(GUARD_BITS);

            logic [CNT_W-1:0] remain;

            // Load on arming, count ticks down, idle at zero.
            always_ff @(posedge clk) begin
                if (!rst_n || !auto_en) begin
                    remain <= '0;
                end else if (arm) begin
                    remain <= CNT_LOAD;
                end else if (bit_tick && remain != '0) begin
                    remain <= remain - 1'b1;
                end
            end

            assign settled = (remain == '0);
        end
    endgenerate

endmodule

// File: rtl/auto_dir_irq.sv
// Module: transmit interrupt source select. Manual mode reports queue empty;
// automatic mode reports queue empty and shift register idle.
// Assumes: status inputs are synchronous to clk.
module auto_dir_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic tx_fifo_empty,
    input  logic tsr_busy,
    output logic irq_q
);

    logic cond;

    // Pick the empty condition for the current mode.
    assign cond = auto_en ? (tx_fifo_empty && !tsr_busy) : tx_fifo_empty;

    // Registered interrupt source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= cond;
        end
    end

endmodule

// File: rtl/auto_dir_ctrl.sv
// Module: top of the automatic half-duplex direction controller.
// Joins the direction register, settling guard and interrupt source select.
// Assumes: all inputs synchronous to clk; auto_en changes only around reset.
module auto_dir_ctrl #(
    parameter int GUARD_BITS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic sw_rts,
    input  logic byte_written,
    input  logic tx_fifo_empty,
    input  logic tsr_busy,
    input  logic stop_bit_done,
    input  logic bit_tick,
    output logic dir_out,
    output logic tx_irq,
    output logic launch_ok
);

    logic arm_guard;
    logic settled;

    auto_dir_line u_line (
        .clk           (clk),
        .rst_n         (rst_n),
        .auto_en       (auto_en),
        .sw_rts        (sw_rts),
        .byte_written  (byte_written),
        .tx_fifo_empty (tx_fifo_empty),
        .stop_bit_done (stop_bit_done),
        .dir_q         (dir_out),
        .arm_guard     (arm_guard)
    );

    auto_dir_guard #(.GUARD_BITS(GUARD_BITS)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (auto_en),
        .arm      (arm_guard),
        .bit_tick (bit_tick),
        .settled  (settled)
    );

    auto_dir_irq u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .auto_en       (auto_en),
        .tx_fifo_empty (tx_fifo_empty),
        .tsr_busy      (tsr_busy),
        .irq_q         (tx_irq)
    );

    // Launch permitted in manual mode, or once the driver is on and settled.
    assign launch_ok = !auto_en || (dir_out && settled);

endmodule

// File: rtl/auto_dir_ctrl_chk.sv
// Module: property checker for auto_dir_ctrl, attached by bind below.
// Assumes: auto_en held steady across the checked cycles.
module auto_dir_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic auto_en,
    input logic byte_written,
    input logic tx_fifo_empty,
    input logic tsr_busy,
    input logic stop_bit_done,
    input logic dir_out,
    input logic tx_irq,
    input logic launch_ok
);

    // R3: manual mode, queue empty gives interrupt next cycle.
    a_r3_manual_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && $past(!auto_en) && $past(rst_n) && $past(tx_fifo_empty)) |-> tx_irq);

    // R4: automatic mode, a write turns the driver on.
    a_r4_write_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && $past(auto_en) && $past(rst_n) && $past(byte_written)) |-> dir_out);

    // R5: automatic mode, final stop bit releases the driver.
    a_r5_last_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && $past(auto_en) && $past(rst_n)
         && $past(stop_bit_done && tx_fifo_empty && !byte_written)) |-> !dir_out);

    // R7: automatic mode, busy shift register suppresses the interrupt.
    a_r7_busy_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && $past(auto_en) && $past(rst_n) && $past(tsr_busy)) |-> !tx_irq);

    // R8: the start bit is held off on the cycle the driver turns on.
    a_r8_guard_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && $past(auto_en) && $past(rst_n) && $rose(dir_out)) |-> !launch_ok);

endmodule

bind auto_dir_ctrl auto_dir_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .auto_en       (auto_en),
    .byte_written  (byte_written),
    .tx_fifo_empty (tx_fifo_empty),
    .tsr_busy      (tsr_busy),
    .stop_bit_done (stop_bit_done),
    .dir_out       (dir_out),
    .tx_irq        (tx_irq),
    .launch_ok     (launch_ok)
);

// File: tb/test_auto_dir_ctrl.sv
// Scoreboard bench: the driver applies one cycle of stimulus and queues the
// expected outputs; the monitor compares them just after the next edge.
module test_auto_dir_ctrl;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_en = 1'b0;
    logic sw_rts = 1'b0;
    logic byte_written = 1'b0;
    logic tx_fifo_empty = 1'b1;
    logic tsr_busy = 1'b0;
    logic stop_bit_done = 1'b0;
    logic bit_tick = 1'b0;
    logic dir_out;
    logic tx_irq;
    logic launch_ok;

    typedef struct {
        logic  dir;
        logic  irq;
        logic  launch;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   cycles   = 0;
    bit   done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    auto_dir_ctrl i_auto_dir_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .auto_en       (auto_en),
        .sw_rts        (sw_rts),
        .byte_written  (byte_written),
        .tx_fifo_empty (tx_fifo_empty),
        .tsr_busy      (tsr_busy),
        .stop_bit_done (stop_bit_done),
        .bit_tick      (bit_tick),
        .dir_out       (dir_out),
        .tx_irq        (tx_irq),
        .launch_ok     (launch_ok)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Monitor: compare outputs shortly after each edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.req, "dir_out",   dir_out,   e.dir);
            check(e.req, "tx_irq",    tx_irq,    e.irq);
            check(e.req, "launch_ok", launch_ok, e.launch);
        end
    end

    // Driver: one cycle of stimulus plus the outputs expected after the edge.
    task automatic step(input logic rst, input logic bw, input logic stop,
                        input logic empty, input logic busy, input logic tick,
                        input logic sw, input logic e_dir, input logic e_irq,
                        input logic e_launch, input string req);
        exp_t e;
        @(negedge clk);
        rst_n         = rst;
        byte_written  = bw;
        stop_bit_done = stop;
        tx_fifo_empty = empty;
        tsr_busy      = busy;
        bit_tick      = tick;
        sw_rts        = sw;
        e.dir = e_dir; e.irq = e_irq; e.launch = e_launch; e.req = req;
        exp_q.push_back(e);
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // Manual mode.            rst bw st em bu tk sw | dir irq lau
        auto_en = 1'b0;
        step(0, 0, 0, 1, 1, 0, 1,  1, 0, 1, "R1 manual reset");
        step(1, 0, 0, 1, 1, 0, 0,  0, 1, 1, "R2 R3 R9 sw low, irq despite busy");
        step(1, 0, 0, 0, 0, 0, 1,  1, 0, 1, "R2 R3 sw high, queue full");
        step(1, 1, 1, 1, 1, 0, 1,  1, 1, 1, "R2 R3 events ignored in manual");
        step(1, 0, 0, 1, 0, 0, 0,  0, 1, 1, "R2 sw low again");

        // Automatic mode.
        @(negedge clk); auto_en = 1'b1;
        step(0, 0, 0, 1, 0, 0, 1,  0, 0, 0, "R1 auto reset");
        step(1, 0, 0, 1, 0, 0, 1,  0, 1, 0, "R7 R9 R10 idle, sw ignored");
        step(1, 1, 0, 0, 0, 1, 1,  1, 0, 0, "R4 R8 write raises, tick same cycle not counted");
        step(1, 0, 0, 0, 1, 0, 1,  1, 0, 0, "R8 guard waiting");
        step(1, 0, 0, 0, 1, 1, 1,  1, 0, 1, "R8 guard expires after tick");
        step(1, 0, 1, 0, 1, 0, 0,  1, 0, 1, "R5 R10 stop with queue not empty");
        step(1, 0, 1, 1, 1, 0, 1,  0, 0, 0, "R5 R7 R9 last stop releases");
        step(1, 0, 0, 1, 0, 0, 1,  0, 1, 0, "R7 R10 shift empty irq, sw ignored");
        step(1, 1, 0, 0, 0, 0, 0,  1, 0, 0, "R4 R8 second write raises");
        step(1, 1, 0, 0, 1, 1, 0,  1, 0, 1, "R8 write while on does not re-arm");
        step(1, 1, 1, 1, 1, 0, 0,  1, 0, 1, "R6 write beats last stop while on");
        step(1, 0, 1, 1, 1, 0, 0,  0, 0, 0, "R5 release");
        step(1, 1, 1, 1, 1, 0, 0,  1, 0, 0, "R6 R8 write beats stop while off, guard armed");
        step(1, 0, 0, 0, 1, 1, 0,  1, 0, 1, "R8 guard expires");
        step(1, 0, 0, 0, 1, 0, 0,  1, 0, 1, "R10 drain");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule